// File: doc/BRIEF.md
# UART receiver with sticky error flags

This block is an asynchronous serial receiver. It assembles 8-bit frames that arrive LSB first. The RX line is sampled at 16 times the bit rate, and an external enable pulse, `tick_i`, marks each sample point.

Software reaches the receiver through a small register port with an address, a write enable, a read strobe and write data. Read data is combinational. The port holds three registers:

- a receive data register;
- a status register with a data-full flag, an overrun flag and a framing flag;
- a control register with the receiver enable and the two-stop-bit select.

The two error flags are sticky. While either flag is set, the receiver accepts no new frame. Software can clear a flag only by a fixed sequence: it reads the status register while the flag is 1, and then writes 0 to that flag's bit.

Top module: `uart_rx_sticky`

## Requirements
- R1: A frame has a low start bit, eight data bits sent LSB first, and a high stop bit. When it is received with reception enabled, the byte loads the data register (address 0) and the data-full flag is set. The data-full flag is status bit 0, at address 1.
- R2: A read strobe at address 0 clears the data-full flag.
- R3: A valid frame may complete while the data-full flag is still 1. In that case the overrun flag (status bit 1) is set, the data register keeps the earlier byte and the data-full flag stays 1.
- R4: When the stop bit is sampled low, the framing flag (status bit 2) is set and the received byte is written to the data register. The data-full flag is left unchanged.
- R5: With control bit 1 set (two stop bits), only the first stop bit is checked. A low second stop bit raises no error and does not start a frame.
- R6: While the overrun flag or the framing flag is 1, incoming frames change neither the data register nor the data-full flag.
- R7: An error flag clears only on a write of 0 to its status bit that follows a status read which returned that flag as 1. Writing 0 without that read, or writing 1, leaves the flag set.
- R8: Clearing the receiver enable (control bit 0, address 2) leaves the overrun and framing flags unchanged. While the enable is 0, no frame is received.
- R9: The start bit is checked at its middle. A low pulse on RX that is high again at mid-bit is discarded, and the receiver returns to idle.
- R10: After reset, the data, status and control registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| we_i | input | 1 | Register write enable |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |

## Verification
The assertions check the following on every cycle:

- an overrun never alters the held byte;
- a framing error never raises data-full;
- a data read always clears data-full unless a frame completes in the same cycle;
- an error flag falls only in the cycle after an armed write of 0;
- the frame engine stays idle while reception is blocked.

Some behaviours can be shown only by the bench's scenarios, because each needs a full serial frame driven on the line:

- LSB-first assembly;
- the byte kept on overrun;
- the ignored second stop bit;
- the rejection of a start glitch;
- the full read-then-write-zero clearing sequence.

A behavioural register model in the bench is compared with the status register on every clock.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CTRL = 2'd2
  } reg_addr_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP1,
    S_STOP2
  } rx_state_e;

  localparam int ST_RDF = 0;
  localparam int ST_OVR = 1;
  localparam int ST_FER = 2;
  localparam int CT_EN  = 0;
  localparam int CT_TWO = 1;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) s_q[0] <= 1'b1;
          else         s_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) s_q[i] <= 1'b1;
          else         s_q[i] <= s_q[i-1];
      end
    end
  endgenerate

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              en_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic              stop_ok_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LBIT = BIT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  os_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shift_q;
  logic              rx_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      os_q      <= '0;
      bit_q     <= '0;
      shift_q   <= '0;
      rx_prev_q <= 1'b1;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      rx_prev_q <= rx_i;
      if (!en_i) begin
        state_q <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            // only a falling edge starts a frame
            if (rx_prev_q && !rx_i) begin
              state_q <= S_START;
              os_q    <= '0;
            end
          end
          S_START: if (tick_i) begin
            if (os_q == MID) begin
              os_q  <= '0;
              bit_q <= '0;
              state_q <= rx_i ? S_IDLE : S_DATA;
            end else os_q <= os_q + 1'b1;
          end
          S_DATA: if (tick_i) begin
            if (os_q == LAST) begin
              os_q    <= '0;
              shift_q <= {rx_i, shift_q[DATA_W-1:1]};
              if (bit_q == LBIT) state_q <= S_STOP1;
              else               bit_q   <= bit_q + 1'b1;
            end else os_q <= os_q + 1'b1;
          end
          S_STOP1: if (tick_i) begin
            if (os_q == LAST) begin
              os_q      <= '0;
              done_o    <= 1'b1;
              stop_ok_o <= rx_i;
              state_q   <= two_stop_i ? S_STOP2 : S_IDLE;
            end else os_q <= os_q + 1'b1;
          end
          S_STOP2: if (tick_i) begin
            // second stop bit is not checked
            if (os_q == LAST) state_q <= S_IDLE;
            else              os_q    <= os_q + 1'b1;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign data_o = shift_q;

  // R6
  idle_when_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (state_q == S_IDLE));
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              done_i,
  input  logic              stop_ok_i,
  input  logic [DATA_W-1:0] frame_i,
  output logic              rx_en_o,
  output logic              two_stop_o
);
  logic [DATA_W-1:0] data_q;
  logic              rdf_q, ovr_q, fer_q;
  logic              ovr_arm_q, fer_arm_q;
  logic              en_q, two_q;

  logic rd_stat, rd_data, wr_stat, wr_ctrl;
  assign rd_stat = rd_i && (addr_i == A_STAT);
  assign rd_data = rd_i && (addr_i == A_DATA);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_ctrl = we_i && (addr_i == A_CTRL);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      rdf_q     <= 1'b0;
      ovr_q     <= 1'b0;
      fer_q     <= 1'b0;
      ovr_arm_q <= 1'b0;
      fer_arm_q <= 1'b0;
      en_q      <= 1'b0;
      two_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[CT_EN];
        two_q <= wdata_i[CT_TWO];
      end
      if (rd_data) rdf_q <= 1'b0;
      if (rd_stat && ovr_q) ovr_arm_q <= 1'b1;
      if (rd_stat && fer_q) fer_arm_q <= 1'b1;
      if (wr_stat && !wdata_i[ST_OVR] && ovr_arm_q) begin
        ovr_q     <= 1'b0;
        ovr_arm_q <= 1'b0;
      end
      if (wr_stat && !wdata_i[ST_FER] && fer_arm_q) begin
        fer_q     <= 1'b0;
        fer_arm_q <= 1'b0;
      end
      // hardware events win over software in the same cycle
      if (done_i) begin
        if (!stop_ok_i) begin
          data_q <= frame_i;
          fer_q  <= 1'b1;
        end else if (rdf_q) begin
          ovr_q  <= 1'b1;
        end else begin
          data_q <= frame_i;
          rdf_q  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DATA: rdata_o = data_q;
      A_STAT: begin
        rdata_o[ST_RDF] = rdf_q;
        rdata_o[ST_OVR] = ovr_q;
        rdata_o[ST_FER] = fer_q;
      end
      A_CTRL: begin
        rdata_o[CT_EN]  = en_q;
        rdata_o[CT_TWO] = two_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign rx_en_o    = en_q && !ovr_q && !fer_q;
  assign two_stop_o = two_q;

  // R2
  rdf_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !done_i) |=> !rdf_q);
  // R3
  ovr_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> (data_q == $past(data_q)) && rdf_q);
  // R4
  fer_no_rdf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fer_q) |-> !$rose(rdf_q));
  // R7
  ovr_clear_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_q) |-> $past(wr_stat && !wdata_i[ST_OVR] && ovr_arm_q));
  // R7
  fer_clear_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fer_q) |-> $past(wr_stat && !wdata_i[ST_FER] && fer_arm_q));
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              rx_s;
  logic              rx_en, two_stop, done, stop_ok;
  logic [DATA_W-1:0] frame;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_s),
    .en_i(rx_en), .two_stop_i(two_stop), .done_o(done),
    .stop_ok_o(stop_ok), .data_o(frame)
  );

  rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_i(done),
    .stop_ok_i(stop_ok), .frame_i(frame), .rx_en_o(rx_en),
    .two_stop_o(two_stop)
  );
endmodule

// File: tb/uart_rx_sticky_tb.sv
module uart_rx_sticky_tb;
  localparam int BT = 64;  // clocks per bit: 16 ticks, one every 4 clocks

  logic       clk = 1'b0, rst_ni = 1'b0, rx = 1'b1, tick = 1'b0;
  logic [1:0] addr = 2'd1;
  logic       we = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] tdiv = 2'd0;

  int n_chk = 0, n_fail = 0;
  bit mon_en = 1'b0;

  // behavioural register model
  logic [7:0] m_data = 8'h00;
  bit m_rdf, m_ovr, m_fer, m_oarm, m_farm, m_en, m_two;

  uart_rx_sticky u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .tick_i(tick), .addr_i(addr),
    .we_i(we), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd2);
  end

  function automatic logic [7:0] m_reg(input logic [1:0] a);
    case (a)
      2'd0:    return m_data;
      2'd1:    return {5'b0, m_fer, m_ovr, m_rdf};
      2'd2:    return {6'b0, m_two, m_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // every-clock comparison of the status register
  always @(posedge clk) begin
    #3;
    if (mon_en && rst_ni && addr == 2'd1) chk("R7 monitor status", rdata, m_reg(2'd1));
  end

  task automatic reg_read(input logic [1:0] a, input string req);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #5 chk(req, rdata, m_reg(a));
    @(posedge clk);
    #1;
    if (a == 2'd0) m_rdf = 1'b0;
    if (a == 2'd1) begin
      if (m_ovr) m_oarm = 1'b1;
      if (m_fer) m_farm = 1'b1;
    end
    rd = 1'b0; addr = 2'd1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = v;
    @(posedge clk);
    #1;
    if (a == 2'd2) begin m_en = v[0]; m_two = v[1]; end
    if (a == 2'd1) begin
      if (!v[1] && m_oarm) begin m_ovr = 1'b0; m_oarm = 1'b0; end
      if (!v[2] && m_farm) begin m_fer = 1'b0; m_farm = 1'b0; end
    end
    we = 1'b0; addr = 2'd1;
  endtask

  task automatic send(input logic [7:0] b, input bit stop1, input bit stop2, input bit two);
    mon_en = 1'b0;
    @(negedge clk);
    rx = 1'b0; repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i]; repeat (BT) @(negedge clk);
    end
    rx = stop1; repeat (BT) @(negedge clk);
    if (two) begin rx = stop2; repeat (BT) @(negedge clk); end
    rx = 1'b1; repeat (2*BT) @(negedge clk);
    if (m_en && !m_ovr && !m_fer) begin
      if (!stop1)     begin m_data = b; m_fer = 1'b1; end
      else if (m_rdf) m_ovr = 1'b1;
      else            begin m_data = b; m_rdf = 1'b1; end
    end
    mon_en = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10
    reg_read(2'd0, "R10 data");
    reg_read(2'd1, "R10 status");
    reg_read(2'd2, "R10 ctrl");
    mon_en = 1'b1;
    // R1 / R2
    reg_write(2'd2, 8'h01);
    send(8'hA5, 1, 1, 0);
    reg_read(2'd1, "R1 rdf set");
    reg_read(2'd0, "R1 data A5");
    reg_read(2'd1, "R2 rdf cleared");
    // R3
    send(8'h3C, 1, 1, 0);
    send(8'h81, 1, 1, 0);
    reg_read(2'd0, "R3 data kept 3C");
    // R7: write 0 without prior status read
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, "R7 ovr kept unarmed");
    reg_write(2'd1, 8'hFF);
    reg_read(2'd1, "R7 ovr kept on write 1");
    // R6
    send(8'h55, 1, 1, 0);
    reg_read(2'd0, "R6 data unchanged");
    reg_read(2'd1, "R6 rdf still clear");
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, "R7 ovr cleared");
    // R4
    send(8'h5A, 0, 1, 0);
    reg_read(2'd1, "R4 fer set no rdf");
    reg_read(2'd0, "R4 data 5A");
    // R8
    reg_write(2'd2, 8'h00);
    reg_read(2'd1, "R8 fer kept with enable off");
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, "R7 fer cleared");
    send(8'h11, 1, 1, 0);
    reg_read(2'd1, "R8 no reception disabled");
    reg_read(2'd0, "R8 data unchanged");
    // R5
    reg_write(2'd2, 8'h03);
    send(8'h96, 1, 0, 1);
    reg_read(2'd1, "R5 no fer on second stop");
    reg_read(2'd0, "R5 data 96");
    send(8'h69, 1, 1, 1);
    reg_read(2'd0, "R5 next frame 69");
    reg_read(2'd1, "R5 status clean");
    // R9
    reg_write(2'd2, 8'h01);
    mon_en = 1'b0;
    @(negedge clk);
    rx = 1'b0; repeat (8) @(negedge clk);
    rx = 1'b1; repeat (3*BT) @(negedge clk);
    mon_en = 1'b1;
    reg_read(2'd1, "R9 glitch ignored");
    send(8'h42, 1, 1, 0);
    reg_read(2'd0, "R9 data 42 after glitch");
    reg_read(2'd1, "R9 status after read");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule